// File: doc/BRIEF.md
# Serial GF(2) Remainder Unit

This block divides a serial bit stream by a polynomial over GF(2) and keeps the remainder. It takes one message bit per clock, most significant coefficient first. The polynomial is a run-time input, so one instance can serve several divisors.

The remainder is an N-bit register. The leading x^N coefficient of the divisor is implied and is not on the port. Each accepted bit shifts the register up by one place. When the bit shifted out of the top is 1, the divisor's lower coefficients are XORed into the register. Each divisor bit gates its own tap.

In every accepted cycle the block also gives the quotient bit of that step. A user clears the register between messages. To get a CRC-style check value, the user appends N zero bits to the message.

Top module: `gf2_serial_rem`

## Requirements
- R1: While `rst` is high at a rising edge, the remainder register loads all zeros.
- R2: While `clr` is high at a rising edge, the remainder register loads all zeros. This takes priority over `in_valid`.
- R3: With `in_valid` low and `clr` low, the remainder register keeps its value, whatever `in_bit` and `poly` do.
- R4: In an accepted cycle (`in_valid` high, `clr` low) with remainder bit N-1 at 0, the next remainder is `{rem[N-2:0], in_bit}`.
- R5: In an accepted cycle with remainder bit N-1 at 1, the next remainder is `{rem[N-2:0], in_bit} ^ poly`. Here `poly[i]` is the coefficient of x^i for i below N, and the x^N coefficient is taken as 1.
- R6: `quo_bit` is high only in an accepted cycle whose remainder bit N-1 is 1. It is low whenever `in_valid` is low or `clr` is high.
- R7: After a clear followed by L accepted bits, `rem_out` equals the stream value modulo the divisor, for any L, including L < N. The first bit sent is the highest power.
- R8: A message followed by N zero bits leaves `rem_out` equal to the message times x^N, modulo the divisor.
- R9: With `poly` all zeros, the block acts as a plain shift register holding the last N accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear before a new message, active high |
| in_valid | input | 1 | Accept `in_bit` this cycle |
| in_bit | input | 1 | Serial message bit, highest power first |
| poly | input | N | Divisor coefficients x^(N-1)..x^0 (x^N implied) |
| rem_out | output | N | Current remainder |
| quo_bit | output | 1 | Quotient bit of the current accepted step |

## Verification
The bench builds the block at the default degree N = 8, which keeps each remainder in one byte while the divisor still changes at run time. With random divisors and random messages from 1 to 40 bits, the comparison covers feedback on every tap position. It also covers messages shorter than the register, and zero-padded messages whose dividend has up to 48 bits. The reference model performs explicit long division on a wide vector, so it shares no structure with the shift-register form.

// File: rtl/gf2_rem_pkg.sv
package gf2_rem_pkg;

    // What the remainder register does in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SHIFT = 2'd2
    } rem_act_e;

    localparam int unsigned DEF_DEGREE = 8;

endpackage

// File: rtl/gf2_tap_cell.sv
// One bit of the divide step: the shifted bit, corrected by the feedback
// only where the coefficient of this tap is set.
module gf2_tap_cell (
    input  logic shifted_bit,
    input  logic feedback,
    input  logic coeff,
    output logic next_bit
);

    always_comb begin
        next_bit = shifted_bit ^ (feedback & coeff);
    end

endmodule

// File: rtl/gf2_div_step.sv
// Combinational single-bit division step over GF(2).
module gf2_div_step #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] cur_rem,
    input  logic         new_bit,
    input  logic [N-1:0] coeffs,
    output logic [N-1:0] nxt_rem,
    output logic         quo
);

    logic [N-1:0] shifted;
    logic         fb;

    always_comb begin
        shifted = {cur_rem[N-2:0], new_bit};
        fb      = cur_rem[N-1];
        quo     = fb;
    end

    for (genvar i = 0; i < N; i++) begin : g_tap
        gf2_tap_cell u_cell (
            .shifted_bit (shifted[i]),
            .feedback    (fb),
            .coeff       (coeffs[i]),
            .next_bit    (nxt_rem[i])
        );
    end

endmodule

// File: rtl/gf2_serial_rem.sv
module gf2_serial_rem
    import gf2_rem_pkg::*;
#(
    parameter int unsigned N = DEF_DEGREE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         in_valid,
    input  logic         in_bit,
    input  logic [N-1:0] poly,
    output logic [N-1:0] rem_out,
    output logic         quo_bit
);

    typedef struct packed {
        logic [N-1:0] rem;
    } rem_state_t;

    rem_state_t   state_d, state_q;
    rem_act_e     act;
    logic [N-1:0] step_rem;
    logic         step_quo;

    gf2_div_step #(.N(N)) u_step (
        .cur_rem (state_q.rem),
        .new_bit (in_bit),
        .coeffs  (poly),
        .nxt_rem (step_rem),
        .quo     (step_quo)
    );

    always_comb begin
        if (clr)           act = ACT_CLEAR;
        else if (in_valid) act = ACT_SHIFT;
        else               act = ACT_HOLD;

        state_d = state_q;
        unique case (act)
            ACT_CLEAR: state_d.rem = '0;
            ACT_SHIFT: state_d.rem = step_rem;
            default:   state_d.rem = state_q.rem;
        endcase

        quo_bit = (act == ACT_SHIFT) && step_quo;
        rem_out = state_q.rem;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/gf2_serial_rem_chk.sv
module gf2_serial_rem_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         clr,
    input logic         in_valid,
    input logic         in_bit,
    input logic [N-1:0] poly,
    input logic [N-1:0] rem_out,
    input logic         quo_bit
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rem_out == '0));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rem_out == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !in_valid) |=> $stable(rem_out));

    // R4
    plain_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && in_valid && !rem_out[N-1]) |=>
            (rem_out == {$past(rem_out[N-2:0]), $past(in_bit)}));

    // R5
    subtract_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && in_valid && rem_out[N-1]) |=>
            (rem_out == ({$past(rem_out[N-2:0]), $past(in_bit)} ^ $past(poly))));

    // R6
    quo_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || clr) |-> !quo_bit);

    // R6
    quo_msb_chk: assert property (@(posedge clk) disable iff (rst)
        quo_bit |-> rem_out[N-1]);

endmodule

bind gf2_serial_rem gf2_serial_rem_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .poly     (poly),
    .rem_out  (rem_out),
    .quo_bit  (quo_bit)
);

// File: tb/tb_gf2_serial_rem.sv
`timescale 1ns/1ps
module tb_gf2_serial_rem;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_bit = 1'b0;
    logic [N-1:0] poly = '0;
    logic [N-1:0] rem_out;
    logic         quo_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gf2_serial_rem #(.N(N)) dut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_bit(in_bit), .poly(poly), .rem_out(rem_out), .quo_bit(quo_bit)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Long division over a wide vector: remainder of msg (len bits) by {1,p}.
    function automatic logic [N-1:0] ref_mod(input logic [63:0] msg,
                                             input int len,
                                             input logic [N-1:0] p);
        logic [63:0] v = msg;
        logic [63:0] d = {{(64-N-1){1'b0}}, 1'b1, p};
        for (int i = len - 1; i >= int'(N); i--)
            if (v[i]) v = v ^ (d << (i - N));
        return v[N-1:0];
    endfunction

    // Accept one bit; inputs change on the falling edge.
    task automatic push(input logic b);
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b1; in_bit = b;
    endtask

    task automatic idle_now();
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic clear_now();
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic send_msg(input logic [63:0] msg, input int len);
        for (int i = len - 1; i >= 0; i--) push(msg[i]);
        idle_now();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(rem_out == '0, "R1 reset", rem_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rem_out == '0, "R1 after reset", rem_out, 0);
    endtask

    task automatic t_steps();
        logic [N-1:0] model;
        logic [N-1:0] exp;
        clear_now();
        poly = 8'h07;
        model = '0;
        for (int k = 0; k < 20; k++) begin
            logic b = ((k % 3) == 0) || (k == 7);
            push(b);
            #1;
            check(quo_bit == model[N-1], "R6 quotient bit", quo_bit, model[N-1]);
            exp = {model[N-2:0], b};
            if (model[N-1]) exp = exp ^ poly;
            @(negedge clk);
            #1;
            check(rem_out == exp, model[N-1] ? "R5 subtract step" : "R4 plain step",
                  rem_out, exp);
            model = exp;
            in_valid = 1'b0;
        end
        idle_now();
    endtask

    task automatic t_hold();
        logic [N-1:0] snap;
        clear_now();
        poly = 8'h1D;
        send_msg(64'h0000_0000_0000_05A3, 16);
        snap = rem_out;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_bit = ~in_bit; poly = ~poly;
            #1;
            check(quo_bit == 1'b0, "R6 no quotient when idle", quo_bit, 0);
        end
        @(negedge clk);
        check(rem_out == snap, "R3 hold", rem_out, snap);
    endtask

    task automatic t_clear();
        poly = 8'h9B;
        send_msg(64'h0000_0000_0000_FFFF, 16);
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
        #1;
        check(quo_bit == 1'b0, "R6 no quotient while clearing", quo_bit, 0);
        @(negedge clk);
        check(rem_out == '0, "R2 clear over valid", rem_out, 0);
        clr = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_random(input bit pad);
        for (int t = 0; t < 60; t++) begin
            logic [N-1:0] p = N'($urandom);
            int len = 1 + int'($urandom % 40);
            logic [63:0] m = {$urandom, $urandom};
            logic [N-1:0] exp;
            m = m & ((64'd1 << len) - 64'd1);
            if (pad) begin
                m = m << N;
                len = len + N;
            end
            poly = p;
            clear_now();
            send_msg(m, len);
            exp = ref_mod(m, len, p);
            check(rem_out == exp, pad ? "R8 padded message" : "R7 message remainder",
                  rem_out, exp);
        end
    endtask

    task automatic t_zero_poly();
        poly = '0;
        clear_now();
        send_msg(64'h0000_0000_000A_C35E, 20);
        check(rem_out == 8'h5E, "R9 shift register", rem_out, 8'h5E);
    endtask

    initial begin
        t_reset();
        t_steps();
        t_hold();
        t_clear();
        t_random(1'b0);
        t_random(1'b1);
        t_zero_poly();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule